// File: doc/BRIEF.md
# Configurable Cache Set Index Unit

This block turns a byte address into a cache set number. The set number comes from one of four index functions, picked at run time by a 3-bit selector. The line size and the number of sets are fixed when the block is elaborated. The same block can also pick a bank: build it with `LINE_BYTES` set to the bank interleave granularity (32 bytes is the usual value) and `NUM_SETS` set to the bank count.

In a last-level cache, the address bits that choose a memory channel carry no useful spread once a request has reached its channel. A strip input removes a parameterised group of those bits. The bits below the group are kept, and the bits above it move down, before any index function runs. Without this, traffic would crowd into a small subset of sets.

The result is registered. `in_valid` qualifies each request. A selector code that has no function, or a hash asked for with a set count it does not support, raises an error flag. In that case the index falls back to the plain low-bit index.

Top module: `cache_set_index`

## Requirements
- R1: Selector code 0 (plain) gives an index equal to address bits [OFF +: IDX_W], where OFF = log2(LINE_BYTES) and IDX_W = log2(NUM_SETS).
- R2: Selector code 1 (fold) gives the plain index XOR address bits [OFF+IDX_W +: IDX_W].
- R3: Selector code 2 (polynomial) sets the low five index bits from fixed XOR trees over absolute address bits. Bit 0 = a7^a12^a15^a17^a18^a21..a25. Bit 1 = a8^a13^a16^a18^a19^a22..a26. Bit 2 = a9^a12^a14^a15^a18..a22^a26. Bit 3 = a10^a13^a15^a16^a19..a23. Bit 4 = a11^a14^a16^a17^a20..a24. This code is defined only for 32 or 64 sets.
- R4: With 64 sets, index bit 5 under selector code 2 equals address bit 12.
- R5: Selector code 3 (folded-window hash) sets the low five index bits to address bits [OFF +: 5] XOR address bits [OFF+10 +: 5]. With 64 sets, bit 5 is address bit OFF+5. This code is defined only for 32 or 64 sets.
- R6: While `strip_en` is 1, the address used by every function has bits [PART_LSB +: PART_BITS] removed. The bits above that group shift down and the bits below it are unchanged.
- R7: Selector codes 4 to 7, or codes 2 and 3 with a set count other than 32 or 64, set `cfg_err` to 1 and give the code-0 index. Codes 0 to 3 with a supported set count give `cfg_err` = 0.
- R8: A request accepted with `in_valid` = 1 appears on `set_idx` and `cfg_err` one clock later, with `out_valid` = 1. A cycle with `in_valid` = 0 gives `out_valid` = 0 on the next cycle and leaves `set_idx` and `cfg_err` unchanged.
- R9: After reset, `out_valid`, `set_idx` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request qualifier |
| addr | input | ADDR_W | Byte address |
| fn_sel | input | 3 | Index function code (0 plain, 1 fold, 2 polynomial, 3 folded-window) |
| strip_en | input | 1 | Remove channel bits before indexing |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| set_idx | output | log2(NUM_SETS) | Set or bank index |
| cfg_err | output | 1 | Unsupported function or set count |

## Verification
Every result is due exactly one rising edge after its request is presented. The bench drives each request on a falling edge and compares `out_valid`, `set_idx` and `cfg_err` on the next falling edge, which follows that single register stage. Idle cycles are checked on the same schedule: `out_valid` must drop and the previous index and flag must still be there. Back-to-back random requests are compared one per cycle, so a stage added or removed anywhere shows up as a miscompare.

// File: rtl/csi_pkg.sv
package csi_pkg;
    typedef enum logic [2:0] {
        FN_PLAIN = 3'd0,
        FN_FOLD  = 3'd1,
        FN_POLY  = 3'd2,
        FN_WIN   = 3'd3
    } csi_fn_e;
endpackage

// File: rtl/csi_strip.sv
module csi_strip #(
    parameter int ADDR_W    = 32,
    parameter int PART_LSB  = 8,
    parameter int PART_BITS = 2
) (
    input  logic              strip_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] part_addr
);
    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << PART_LSB) - ADDR_W'(1);

    always_comb begin
        if (strip_en)
            part_addr = ((addr >> PART_BITS) & ~LOW_MASK) | (addr & LOW_MASK);
        else
            part_addr = addr;
    end
endmodule

// File: rtl/csi_hash.sv
module csi_hash
    import csi_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int NUM_SETS   = 64
) (
    input  logic [ADDR_W-1:0]           pa,
    input  logic [2:0]                  sel,
    output logic [$clog2(NUM_SETS)-1:0] idx,
    output logic                        err
);
    localparam int OFF     = $clog2(LINE_BYTES);
    localparam int IDX_W   = $clog2(NUM_SETS);
    localparam bit HASH_OK = (NUM_SETS == 32) || (NUM_SETS == 64);

    logic [IDX_W-1:0] plain_v, fold_v, poly_v, win_v;
    logic [5:0]       poly6, win6;

    always_comb begin
        plain_v = pa[OFF +: IDX_W];
        fold_v  = plain_v ^ pa[OFF+IDX_W +: IDX_W];

        poly6[0] = pa[25]^pa[24]^pa[23]^pa[22]^pa[21]^pa[18]^pa[17]^pa[15]^pa[12]^pa[7];
        poly6[1] = pa[26]^pa[25]^pa[24]^pa[23]^pa[22]^pa[19]^pa[18]^pa[16]^pa[13]^pa[8];
        poly6[2] = pa[26]^pa[22]^pa[21]^pa[20]^pa[19]^pa[18]^pa[15]^pa[14]^pa[12]^pa[9];
        poly6[3] = pa[23]^pa[22]^pa[21]^pa[20]^pa[19]^pa[16]^pa[15]^pa[13]^pa[10];
        poly6[4] = pa[24]^pa[23]^pa[22]^pa[21]^pa[20]^pa[17]^pa[16]^pa[14]^pa[11];
        poly6[5] = pa[12];
        poly_v   = IDX_W'(poly6);

        win6[4:0] = pa[OFF +: 5] ^ pa[OFF+10 +: 5];
        win6[5]   = pa[OFF+5];
        win_v     = IDX_W'(win6);

        err = 1'b0;
        idx = plain_v;
        case (sel)
            FN_PLAIN: idx = plain_v;
            FN_FOLD:  idx = fold_v;
            FN_POLY:  if (HASH_OK) idx = poly_v; else err = 1'b1;
            FN_WIN:   if (HASH_OK) idx = win_v;  else err = 1'b1;
            default:  err = 1'b1;
        endcase
    end
endmodule

// File: rtl/cache_set_index.sv
module cache_set_index
    import csi_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int NUM_SETS   = 64,
    parameter int PART_LSB   = 8,
    parameter int PART_BITS  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [2:0]                  fn_sel,
    input  logic                        strip_en,
    output logic                        out_valid,
    output logic [$clog2(NUM_SETS)-1:0] set_idx,
    output logic                        cfg_err
);
    localparam int OFF   = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(NUM_SETS);

    typedef struct packed {
        logic             vld;
        logic             err;
        logic [IDX_W-1:0] idx;
    } out_t;

    out_t             st_d, st_q;
    logic [ADDR_W-1:0] part_addr;
    logic [IDX_W-1:0]  hash_idx;
    logic              hash_err;

    csi_strip #(.ADDR_W(ADDR_W), .PART_LSB(PART_LSB), .PART_BITS(PART_BITS)) u_strip (
        .strip_en (strip_en),
        .addr     (addr),
        .part_addr(part_addr)
    );

    csi_hash #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NUM_SETS(NUM_SETS)) u_hash (
        .pa (part_addr),
        .sel(fn_sel),
        .idx(hash_idx),
        .err(hash_err)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.idx = hash_idx;
            st_d.err = hash_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign set_idx   = st_q.idx;
    assign cfg_err   = st_q.err;

    a_r8_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(set_idx) && $stable(cfg_err)));
    a_r7_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fn_sel > 3'd3) |=> (cfg_err && set_idx == $past(part_addr[OFF +: IDX_W])));
    a_r1_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fn_sel == 3'd0 && !strip_en) |=> (set_idx == $past(addr[OFF +: IDX_W]) && !cfg_err));

    generate
        if (NUM_SETS == 64) begin : g_poly64
            a_r4_poly_top: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && fn_sel == 3'd2 && !strip_en) |=> (set_idx[5] == $past(addr[12])));
        end
    endgenerate
endmodule

// File: tb/tb_cache_set_index.sv
module tb_cache_set_index;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] addr = '0;
    logic [2:0]  fn_sel = '0;
    logic        strip_en = 1'b0;
    logic        out_valid;
    logic [5:0]  set_idx;
    logic        cfg_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cache_set_index dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr(addr),
        .fn_sel(fn_sel), .strip_en(strip_en), .out_valid(out_valid),
        .set_idx(set_idx), .cfg_err(cfg_err)
    );

    function automatic logic [31:0] strip_f(input logic [31:0] a);
        return {2'b00, a[31:10], a[7:0]};
    endfunction

    function automatic logic [6:0] ref_f(input logic [31:0] a0, input logic [2:0] s, input logic st);
        logic [31:0] a;
        logic [5:0]  r;
        a = st ? strip_f(a0) : a0;
        case (s)
            3'd0: r = a[12:7];
            3'd1: r = a[12:7] ^ a[18:13];
            3'd2: begin
                r[0] = a[7]^a[12]^a[15]^a[17]^a[18]^a[21]^a[22]^a[23]^a[24]^a[25];
                r[1] = a[8]^a[13]^a[16]^a[18]^a[19]^a[22]^a[23]^a[24]^a[25]^a[26];
                r[2] = a[9]^a[12]^a[14]^a[15]^a[18]^a[19]^a[20]^a[21]^a[22]^a[26];
                r[3] = a[10]^a[13]^a[15]^a[16]^a[19]^a[20]^a[21]^a[22]^a[23];
                r[4] = a[11]^a[14]^a[16]^a[17]^a[20]^a[21]^a[22]^a[23]^a[24];
                r[5] = a[12];
            end
            3'd3: r = {a[12], a[11:7] ^ a[21:17]};
            default: r = a[12:7];
        endcase
        return {(s > 3'd3), r};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic [31:0] a, input logic [2:0] s, input logic st);
        logic [6:0] e;
        e = ref_f(a, s, st);
        in_valid = 1'b1; addr = a; fn_sel = s; strip_en = st;
        @(negedge clk);
        chk(req, {out_valid, cfg_err, set_idx}, {1'b1, e});
    endtask

    function automatic string tag_f(input logic [2:0] s, input logic st);
        if (s > 3'd3) return "R7";
        if (st) return "R6";
        case (s)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk("R9", {out_valid, cfg_err, set_idx}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        apply("R1", 32'h0000_1F80, 3'd0, 1'b0);
        apply("R2", 32'h0007_E000, 3'd1, 1'b0);
        apply("R2", 32'h0003_2180, 3'd1, 1'b0);
        apply("R3", 32'h0000_0080, 3'd2, 1'b0);
        apply("R3", 32'h0400_0000, 3'd2, 1'b0);
        apply("R4", 32'h0000_1000, 3'd2, 1'b0);
        apply("R5", 32'h0022_0000, 3'd3, 1'b0);
        apply("R5", 32'h0000_1F80, 3'd3, 1'b0);
        apply("R6", 32'h0000_0300, 3'd0, 1'b1);
        apply("R6", 32'h0000_1C00, 3'd0, 1'b1);
        apply("R7", 32'h0000_1A80, 3'd4, 1'b0);
        apply("R7", 32'hFFFF_FFFF, 3'd7, 1'b0);
        held = {1'b0, cfg_err, set_idx};
        in_valid = 1'b0; addr = 32'h0000_0F80; fn_sel = 3'd0;
        @(negedge clk);
        chk("R8", {out_valid, cfg_err, set_idx}, held);
        apply("R8", 32'h0000_0F80, 3'd0, 1'b0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            logic [2:0]  s;
            logic        st;
            a  = $urandom;
            s  = 3'($urandom_range(0, 7));
            st = 1'($urandom_range(0, 1));
            apply(tag_f(s, st), a, s, st);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule